// File: doc/BRIEF.md
# Multi-Waveform Tone Generator

This block produces a digital audio tone from a single 24-bit phase accumulator. On every sample strobe the accumulator advances by an increment derived from a raw 10-bit pitch-axis reading. Its top 8 bits form a phase address. That address either indexes a 256-entry sine ROM or is reshaped by arithmetic into a square, triangle or sawtooth wave. The chosen 12-bit wave is multiplied by an 8-bit volume factor taken from the raw 10-bit volume-axis reading. The result is registered as an unsigned 12-bit sample.

A push button steps through the waveforms. The button is synchronised, debounced and edge-detected, so a single press advances the selection exactly once. The block runs on one system clock, nominally 100 MHz. A sample strobe one clock wide sets the audio rate.

The output is a stream with a valid flag and no ready. Each sample is presented for exactly one clock while valid is high. The sink cannot apply back-pressure, so it must accept every sample in the cycle after the strobe. Between strobes the sample value is held.

Top module: `tone_synth_core`

## Requirements
- R1: After a synchronous reset, `sample_o` is 0 and `sample_valid_o` is 0. The phase accumulator is 0 and the sine waveform is selected.
- R2: At each clock edge where `tick_i` is 1, the 24-bit accumulator adds `(joy_x_i + 1) << 4`, modulo 2^24. Without a strobe the accumulator holds its value. The phase address is accumulator bits [23:16].
- R3: Sine (selection code 0) takes address p and h = p mod 128. It computes v = min((h*(128-h)) >> 1, 2047). The wave is 2048 + v when p < 128, and 2048 - v otherwise.
- R4: Square (code 1) is 4095 when address bit 7 is 0, and 0 when it is 1.
- R5: Sawtooth (code 3) is the phase address shifted left by 4.
- R6: Triangle (code 2) forms a 7-bit value t. It is p[6:0] when p[7] is 0, and the bitwise inverse of p[6:0] when p[7] is 1. The wave is t shifted left by 5.
- R7: The output sample is (wave * vol) >> 8, where vol = `joy_y_i` >> 2, an 8-bit value.
- R8: On a strobe edge the sample is computed from the phase before that edge's addition. `sample_valid_o` is 1 for exactly the next clock. `sample_o` holds its value until the next strobe.
- R9: Each accepted press advances the selection in the order sine, square, triangle, sawtooth, then back to sine. Holding the button gives no further advance.
- R10: A button level change takes effect only after it has persisted for 4 consecutive synchronised clocks. Shorter pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Sample strobe, one clock wide |
| joy_x_i | input | 10 | Raw pitch-axis reading |
| joy_y_i | input | 10 | Raw volume-axis reading |
| btn_i | input | 1 | Asynchronous waveform-select button |
| sample_o | output | 12 | Scaled unsigned audio sample |
| sample_valid_o | output | 1 | High for one clock when a new sample is presented |

## Verification
- **Sine sweep:** a full-rate pitch sweep at full volume walks the sine through all 256 phase addresses. This separates ROM content errors from errors in address extraction.
- **Other shapes:** the square, triangle and sawtooth waves are each run over whole periods at more than one pitch. This distinguishes a wrong increment from a wrong reshaping.
- **Volume:** zero, mid and full volume settings reveal truncation and scaling mistakes.
- **Button:** a long hold, a short glitch and four successive presses check single-step advance, filtering and wrap-around. All of these are observed only through the sample values.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef enum logic [1:0] {
    WAVE_SINE   = 2'd0,
    WAVE_SQUARE = 2'd1,
    WAVE_TRI    = 2'd2,
    WAVE_SAW    = 2'd3
  } wave_e;

  // Parabolic half-wave approximation of a sine, offset to unsigned mid-scale.
  function automatic int unsigned sine_point(int unsigned idx,
                                             int unsigned addr_w,
                                             int unsigned amp_w);
    int unsigned half;
    int unsigned h;
    int unsigned v;
    int unsigned lim;
    int unsigned mid;
    half = 1 << (addr_w - 1);
    h    = idx % half;
    v    = ((h * (half - h)) << (amp_w + 1)) >> (2 * (addr_w - 1));
    lim  = (1 << (amp_w - 1)) - 1;
    mid  = 1 << (amp_w - 1);
    if (v > lim) v = lim;
    return (idx >= half) ? (mid - v) : (mid + v);
  endfunction

endpackage

// File: rtl/tone_phase_accum.sv
module tone_phase_accum #(
  parameter int ACC_W     = 24,
  parameter int AXIS_W    = 10,
  parameter int INC_SHIFT = 4,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [AXIS_W-1:0] pitch_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int PAD_W = ACC_W - AXIS_W - 1;

  logic [AXIS_W:0]  step;
  logic [ACC_W-1:0] inc;
  logic [ACC_W-1:0] phase_q;

  assign step   = {1'b0, pitch_i} + {{AXIS_W{1'b0}}, 1'b1};
  assign inc    = {{PAD_W{1'b0}}, step} << INC_SHIFT;
  assign addr_o = phase_q[ACC_W-1 -: ADDR_W];

  always_ff @(posedge clk) begin
    if (rst)         phase_q <= '0;
    else if (tick_i) phase_q <= phase_q + inc;
  end

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(phase_q));

  // R2
  phase_moves_chk: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> phase_q != $past(phase_q));

endmodule

// File: rtl/tone_wave_cycler.sv
module tone_wave_cycler
  import tone_pkg::*;
#(
  parameter int DB_CYCLES = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  btn_i,
  output wave_e sel_o
);
  localparam int CNT_W = $clog2(DB_CYCLES + 1);

  logic             sync1_q, sync2_q;
  logic             level_q;
  logic [CNT_W-1:0] cnt_q;
  wave_e            sel_q;
  logic             accept;

  assign accept = (sync2_q != level_q) && (cnt_q == CNT_W'(DB_CYCLES - 1));
  assign sel_o  = sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= btn_i;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else if (sync2_q == level_q) begin
      cnt_q   <= '0;
    end else if (accept) begin
      level_q <= sync2_q;
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 sel_q <= WAVE_SINE;
    else if (accept && sync2_q) sel_q <= wave_e'(sel_q + 2'd1);
  end

  // R9
  sel_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sel_q == $past(sel_q)) || (sel_q == wave_e'($past(sel_q) + 2'd1)));

  // R10
  level_filter_chk: assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |-> (level_q == $past(sync2_q)));

endmodule

// File: rtl/tone_wave_shaper.sv
module tone_wave_shaper
  import tone_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  wave_e             sel_i,
  output logic [AMP_W-1:0]  wave_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int UP_SH  = AMP_W - ADDR_W;
  localparam int HALF_W = ADDR_W - 1;

  logic [AMP_W-1:0]  rom [DEPTH];
  logic [AMP_W-1:0]  sine_w, square_w, tri_w, saw_w;
  logic [HALF_W-1:0] fold;
  logic [ADDR_W-1:0] tri_base;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = AMP_W'(sine_point(i, ADDR_W, AMP_W));
  end

  assign sine_w   = rom[addr_i];
  assign square_w = addr_i[ADDR_W-1] ? '0 : {AMP_W{1'b1}};
  assign fold     = addr_i[ADDR_W-1] ? ~addr_i[HALF_W-1:0] : addr_i[HALF_W-1:0];
  assign tri_base = {fold, 1'b0};
  assign tri_w    = {tri_base, {UP_SH{1'b0}}};
  assign saw_w    = {addr_i, {UP_SH{1'b0}}};

  always_comb begin
    unique case (sel_i)
      WAVE_SINE:   wave_o = sine_w;
      WAVE_SQUARE: wave_o = square_w;
      WAVE_TRI:    wave_o = tri_w;
      default:     wave_o = saw_w;
    endcase
  end

endmodule

// File: rtl/tone_synth_core.sv
module tone_synth_core
  import tone_pkg::*;
#(
  parameter int ACC_W     = 24,
  parameter int ADDR_W    = 8,
  parameter int AMP_W     = 12,
  parameter int AXIS_W    = 10,
  parameter int VOL_W     = 8,
  parameter int INC_SHIFT = 4,
  parameter int DB_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [AXIS_W-1:0] joy_x_i,
  input  logic [AXIS_W-1:0] joy_y_i,
  input  logic              btn_i,
  output logic [AMP_W-1:0]  sample_o,
  output logic              sample_valid_o
);
  localparam int VOL_LSB = AXIS_W - VOL_W;
  localparam int PROD_W  = AMP_W + VOL_W;

  logic [ADDR_W-1:0] addr;
  wave_e             sel;
  logic [AMP_W-1:0]  wave;
  logic [VOL_W-1:0]  vol;
  logic [PROD_W-1:0] prod;
  logic [AMP_W-1:0]  scaled;

  tone_phase_accum #(
    .ACC_W(ACC_W), .AXIS_W(AXIS_W), .INC_SHIFT(INC_SHIFT), .ADDR_W(ADDR_W)
  ) u_accum (
    .clk(clk), .rst(rst), .tick_i(tick_i), .pitch_i(joy_x_i), .addr_o(addr)
  );

  tone_wave_cycler #(.DB_CYCLES(DB_CYCLES)) u_cycler (
    .clk(clk), .rst(rst), .btn_i(btn_i), .sel_o(sel)
  );

  tone_wave_shaper #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_shaper (
    .addr_i(addr), .sel_i(sel), .wave_o(wave)
  );

  if (VOL_LSB > 0) begin : g_vol_trim
    logic y_unused;
    assign y_unused = ^joy_y_i[VOL_LSB-1:0];
    assign vol      = joy_y_i[AXIS_W-1:VOL_LSB];
  end else begin : g_vol_full
    assign vol = joy_y_i[VOL_W-1:0];
  end

  assign prod   = {{VOL_W{1'b0}}, wave} * {{AMP_W{1'b0}}, vol};
  assign scaled = AMP_W'(prod >> VOL_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o       <= '0;
      sample_valid_o <= 1'b0;
    end else begin
      sample_valid_o <= tick_i;
      if (tick_i) sample_o <= scaled;
    end
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid_o |-> $past(tick_i));

  // R8
  sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(sample_o));

  // R7
  vol_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && vol == '0) |=> sample_o == '0);

endmodule

// File: tb/tone_synth_core_tb.sv
module tone_synth_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [9:0]  jx = '0;
  logic [9:0]  jy = '0;
  logic        btn = 1'b0;
  logic [11:0] sample;
  logic        valid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [23:0] model_acc = '0;
  int exp_sel = 0;

  always #4 clk = ~clk;

  tone_synth_core u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .joy_x_i(jx), .joy_y_i(jy),
    .btn_i(btn), .sample_o(sample), .sample_valid_o(valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_wave(input int sel, input int p);
    int h, v, t;
    case (sel)
      0: begin
        h = p % 128;
        v = (h * (128 - h)) >> 1;
        if (v > 2047) v = 2047;
        return (p < 128) ? 2048 + v : 2048 - v;
      end
      1: return (p < 128) ? 4095 : 0;
      2: begin
        t = (p >= 128) ? ((~p) & 127) : (p & 127);
        return t << 5;
      end
      default: return p << 4;
    endcase
  endfunction

  // one strobe; checks value, one-cycle valid and hold afterwards
  task automatic tick_check(input string req);
    int e;
    e = (exp_wave(exp_sel, int'(model_acc[23:16])) * (int'(jy) >> 2)) >> 8;
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    chk(valid === 1'b1, "R8 valid", int'(valid), 1);
    chk(sample === 12'(e), req, int'(sample), e);
    model_acc = model_acc + 24'((int'(jx) + 1) << 4);
    @(negedge clk);
    chk(valid === 1'b0 && sample === 12'(e), "R8 hold", int'(sample), e);
  endtask

  task automatic press(input int hold);
    @(negedge clk) btn = 1'b1;
    repeat (hold) @(negedge clk);
    btn = 1'b0;
    repeat (20) @(negedge clk);
    exp_sel = (exp_sel + 1) % 4;
  endtask

  task automatic t_reset;
    chk(sample === 12'd0, "R1 sample", int'(sample), 0);
    chk(valid === 1'b0, "R1 valid", int'(valid), 0);
    jx = 10'd1023; jy = 10'd1023;
    tick_check("R1 first sine sample");
  endtask

  task automatic t_sine_sweep;
    jx = 10'd1023; jy = 10'd1023;
    for (int i = 0; i < 1030; i++) tick_check("R3 sine");
  endtask

  task automatic t_pitch;
    jy = 10'd1023;
    jx = 10'd0;
    for (int i = 0; i < 20; i++) tick_check("R2 min increment");
    jx = 10'd511;
    for (int i = 0; i < 40; i++) tick_check("R2 mid increment");
    jx = 10'd300;
    for (int i = 0; i < 40; i++) tick_check("R2 odd increment");
    // no strobe for a while: phase must not move
    repeat (30) @(negedge clk);
    tick_check("R2 hold without strobe");
  endtask

  task automatic t_volume;
    jx = 10'd700;
    jy = 10'd0;
    for (int i = 0; i < 10; i++) tick_check("R7 zero volume");
    jy = 10'd514;
    for (int i = 0; i < 20; i++) tick_check("R7 mid volume");
    jy = 10'd3;
    for (int i = 0; i < 10; i++) tick_check("R7 low bits dropped");
    jy = 10'd1023;
  endtask

  task automatic t_shapes;
    jx = 10'd1023; jy = 10'd1023;
    press(40);
    for (int i = 0; i < 1030; i++) tick_check("R4 square after long hold R9");
    press(6);
    for (int i = 0; i < 1030; i++) tick_check("R6 triangle");
    jx = 10'd400;
    for (int i = 0; i < 60; i++) tick_check("R6 triangle other pitch");
    jx = 10'd1023;
    press(6);
    for (int i = 0; i < 1030; i++) tick_check("R5 sawtooth");
    press(6);
    for (int i = 0; i < 30; i++) tick_check("R9 wrap to sine");
  endtask

  task automatic t_glitch;
    jx = 10'd1023; jy = 10'd1023;
    @(negedge clk) btn = 1'b1;
    repeat (2) @(negedge clk);
    btn = 1'b0;
    repeat (20) @(negedge clk);
    for (int i = 0; i < 40; i++) tick_check("R10 short pulse ignored");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sine_sweep();
    t_pitch();
    t_volume();
    t_glitch();
    t_shapes();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule